// File: doc/BRIEF.md
# Programmable Pullup Pin Bank

This block runs a bank of general-purpose pins from one control byte. Each pin has two control bits. A level bit asks for the pin to be held low or released. A pull-off bit decides whether the internal pullup is active. The block never drives a pin high. A released pin rises through its pullup, floats, or follows whatever an external device drives onto it.

The block also returns a read-only state byte. Its low half holds the actual pin levels, taken through a two-flop synchroniser. Its high half is always zero. Per pin, the block gives the pad an output enable, a drive value and a pullup enable. The surrounding pad logic, or the bench, combines these with any external driver to form the pin level fed back on `pad_di`.

Top module: `pio_bank`

## Requirements
- R1: On synchronous reset the control byte becomes 0Fh. Every pin is then released (`pad_oe` = 0) with its pullup active (`pad_pu_en` = 1). While reset is held, `state_byte` reads 00h.
- R2: The control byte takes `ctrl_din` on a rising clock edge where `ctrl_we` is 1. While `ctrl_we` is 0, changes on `ctrl_din` have no effect on any output.
- R3: When level bit i (control bit i) is 0, pin i is actively driven low: `pad_oe[i]` = 1 and `pad_do[i]` = 0.
- R4: When level bit i is 1, pin i is not driven (`pad_oe[i]` = 0), whatever its pull-off bit holds.
- R5: Control bit 4+i is the active-low pullup select of pin i: `pad_pu_en[i]` = NOT bit 4+i. This holds independently of the level bit.
- R6: The bit-to-pin mapping is fixed. Bit i and bit 4+i act on pin i only, for i = 0 to 3.
- R7: Bits 7 to 4 of `state_byte` are always 0.
- R8: Bit i of `state_byte` shows `pad_di[i]` as it stood at the rising edge two edges earlier. A change is therefore visible after exactly the second rising edge.
- R9: On a released pin, the state bit follows an external driver when one is present. Otherwise it follows the pullup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_din | input | 8 | New control byte: bits 7..4 pull-off, bits 3..0 level |
| pad_di | input | 4 | Resolved pin levels from the pads |
| pad_oe | output | 4 | Per-pin output enable (drive low) |
| pad_do | output | 4 | Per-pin drive value, always 0 |
| pad_pu_en | output | 4 | Per-pin pullup enable |
| state_byte | output | 8 | Upper half zero, lower half synchronised pin levels |

## Verification
The bench combines the pad outputs with an external driver model to form `pad_di`. It then tests every pairing of level bit, pull-off bit and external drive.

- A decoder that drove pins high, or tied the pullup to the level bit, shows up as a wrong `pad_oe` or `pad_pu_en`. It also shows up as a wrong level read back on a released pin.
- A directed step on the external levels pins down the two-edge readback latency. A synchroniser of the wrong length shows a value one edge early or late.
- Walking single-bit patterns catch swapped bit positions.
- Random bytes presented with the write strobe low catch a register that ignores its enable.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // Control bits for one pin, taken from the shared control byte
    typedef struct packed {
        logic pull_off;   // 1 = internal pullup disabled
        logic level;      // 0 = hold low, 1 = release
    } pin_cfg_t;

    // Drive request for one pad
    typedef struct packed {
        logic oe;
        logic dout;
        logic pu_en;
    } pin_drv_t;

    // Open-drain style decode: only a low level is ever driven
    function automatic pin_drv_t decode_pin(pin_cfg_t cfg);
        pin_drv_t d;
        d.oe    = ~cfg.level;
        d.dout  = 1'b0;
        d.pu_en = ~cfg.pull_off;
        return d;
    endfunction

    // Reset control value: all pins released, all pullups on
    function automatic logic [15:0] ctrl_reset_value(int unsigned pins);
        logic [15:0] v;
        v = '0;
        for (int unsigned k = 0; k < pins; k++) begin
            v[k] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= din;
        end
    end
endmodule

// File: rtl/pio_pin_drv.sv
module pio_pin_drv
    import pio_pkg::*;
(
    input  pin_cfg_t cfg_i,
    output pin_drv_t drv_o
);
    always_comb begin
        drv_o = decode_pin(cfg_i);
    end
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(STAGES); k++) begin
                stg[k] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int k = 1; k < int'(STAGES); k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int unsigned N_PINS      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_we,
    input  logic [2*N_PINS-1:0]   ctrl_din,
    input  logic [N_PINS-1:0]     pad_di,
    output logic [N_PINS-1:0]     pad_oe,
    output logic [N_PINS-1:0]     pad_do,
    output logic [N_PINS-1:0]     pad_pu_en,
    output logic [2*N_PINS-1:0]   state_byte
);
    localparam int unsigned CW = 2 * N_PINS;
    localparam logic [15:0] RST_FULL = ctrl_reset_value(N_PINS);
    localparam logic [CW-1:0] CTRL_RST = RST_FULL[CW-1:0];

    logic [CW-1:0]     ctrl_q;
    logic [N_PINS-1:0] pin_sync;
    pin_drv_t          drv [N_PINS];

    pio_ctrl_reg #(
        .WIDTH   (CW),
        .RST_VAL (CTRL_RST)
    ) u_ctrl (
        .clk (clk),
        .rst (rst),
        .we  (ctrl_we),
        .din (ctrl_din),
        .q   (ctrl_q)
    );

    for (genvar i = 0; i < int'(N_PINS); i++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg.pull_off = ctrl_q[N_PINS + i];
        assign cfg.level    = ctrl_q[i];

        pio_pin_drv u_drv (
            .cfg_i (cfg),
            .drv_o (drv[i])
        );

        assign pad_oe[i]    = drv[i].oe;
        assign pad_do[i]    = drv[i].dout;
        assign pad_pu_en[i] = drv[i].pu_en;
    end

    pio_sync #(
        .WIDTH  (N_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_di),
        .q   (pin_sync)
    );

    assign state_byte = {{N_PINS{1'b0}}, pin_sync};
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
    parameter int unsigned N_PINS      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                ctrl_we,
    input logic [2*N_PINS-1:0] ctrl_din,
    input logic [2*N_PINS-1:0] ctrl_q,
    input logic [N_PINS-1:0]   pad_di,
    input logic [N_PINS-1:0]   pad_oe,
    input logic [N_PINS-1:0]   pad_do,
    input logic [N_PINS-1:0]   pad_pu_en,
    input logic [2*N_PINS-1:0] state_byte
);
    logic [3:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= '0;
        else if (warm != 4'hF) warm <= warm + 4'd1;
    end

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q[N_PINS-1:0] == {N_PINS{1'b1}}) && (ctrl_q[2*N_PINS-1:N_PINS] == '0));

    assert_write_load_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_q == $past(ctrl_din));

    assert_write_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_we && warm != 4'd0) |=> $stable(ctrl_q));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        state_byte[2*N_PINS-1:N_PINS] == '0);

    for (genvar i = 0; i < int'(N_PINS); i++) begin : g_pin_chk
        assert_drive_low_R3: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[i] |-> (pad_oe[i] && !pad_do[i]));

        assert_release_R4: assert property (@(posedge clk) disable iff (rst)
            ctrl_q[i] |-> !pad_oe[i]);

        assert_pullup_sel_R5: assert property (@(posedge clk) disable iff (rst)
            pad_pu_en[i] != ctrl_q[N_PINS + i]);
    end

    if (SYNC_STAGES == 2) begin : g_lat
        assert_sync_latency_R8: assert property (@(posedge clk) disable iff (rst)
            (warm >= 4'd2) |-> state_byte[N_PINS-1:0] == $past(pad_di, 2));
    end
endmodule

bind pio_bank pio_bank_chk #(
    .N_PINS      (N_PINS),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_din   (ctrl_din),
    .ctrl_q     (ctrl_q),
    .pad_di     (pad_di),
    .pad_oe     (pad_oe),
    .pad_do     (pad_do),
    .pad_pu_en  (pad_pu_en),
    .state_byte (state_byte)
);

// File: tb/pio_bank_test.sv
`timescale 1ns/1ps
module pio_bank_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_we;
    logic [7:0] ctrl_din;
    logic [3:0] pad_di;
    logic [3:0] pad_oe, pad_do, pad_pu_en;
    logic [7:0] state_byte;

    logic [3:0] ext_en, ext_val;
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pio_bank uut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_din   (ctrl_din),
        .pad_di     (pad_di),
        .pad_oe     (pad_oe),
        .pad_do     (pad_do),
        .pad_pu_en  (pad_pu_en),
        .state_byte (state_byte)
    );

    // Pad resolution: own drive wins, then external driver, then pullup,
    // otherwise a floating pin is modelled as reading low.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            if (pad_oe[i])       pad_di[i] = pad_do[i];
            else if (ext_en[i])  pad_di[i] = ext_val[i];
            else if (pad_pu_en[i]) pad_di[i] = 1'b1;
            else                 pad_di[i] = 1'b0;
        end
    end

    function automatic logic [3:0] exp_level(logic [7:0] c, logic [3:0] een, logic [3:0] ev);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            if (!c[i])        r[i] = 1'b0;
            else if (een[i])  r[i] = ev[i];
            else if (!c[4+i]) r[i] = 1'b1;
            else              r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Write a control byte and an external pattern, then check drive and readback
    task automatic apply(logic [7:0] c, logic [3:0] een, logic [3:0] ev);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_din = c; ext_en = een; ext_val = ev;
        @(negedge clk);
        ctrl_we = 1'b0; ctrl_din = 8'($urandom);
        chk("R3/R4 oe", {4'h0, pad_oe}, {4'h0, ~c[3:0]});
        chk("R3 do", {4'h0, pad_do}, 8'h00);
        chk("R5/R6 pu", {4'h0, pad_pu_en}, {4'h0, ~c[7:4]});
        @(negedge clk);
        ctrl_din = 8'($urandom);
        @(negedge clk);
        chk("R7/R8/R9 state", state_byte, {4'h0, exp_level(c, een, ev)});
        chk("R2 ignore oe", {4'h0, pad_oe}, {4'h0, ~c[3:0]});
        chk("R2 ignore pu", {4'h0, pad_pu_en}, {4'h0, ~c[7:4]});
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; ctrl_we = 1'b0; ctrl_din = 8'h00; ext_en = 4'h0; ext_val = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 state in reset", state_byte, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe", {4'h0, pad_oe}, 8'h00);
        chk("R1 pu", {4'h0, pad_pu_en}, 8'h0F);
        @(negedge clk);
        chk("R1 state pulled", state_byte, 8'h0F);

        // R2: write strobe low, data changes must be ignored
        @(negedge clk);
        ctrl_din = 8'h00;
        repeat (3) @(negedge clk);
        chk("R2 no write oe", {4'h0, pad_oe}, 8'h00);
        chk("R2 no write pu", {4'h0, pad_pu_en}, 8'h0F);

        // R3: all driven low, pullups off and on, external trying high
        apply(8'hF0, 4'hF, 4'hF);
        apply(8'h00, 4'h0, 4'h0);
        // R4/R9: released, no pullup, external drives pattern
        apply(8'hFF, 4'hF, 4'hA);
        // R4/R9: released, pullup on, no external
        apply(8'h0F, 4'h0, 4'h0);
        // R9: released, no pullup, no external -> floating reads low in model
        apply(8'hFF, 4'h0, 4'h0);

        // R6: walking patterns per pin
        for (int i = 0; i < 4; i++) begin
            apply(8'hFF & ~(8'h01 << i), 4'h0, 4'h0);
            apply(8'h0F & ~(8'h00) & ~(8'h10 << i) | (8'hF0 & ~(8'h10 << i)), 4'h0, 4'h0);
        end

        // R8: exact two-edge latency on an external step
        apply(8'hFF, 4'hF, 4'h0);
        @(negedge clk);
        ext_val = 4'h5;
        @(negedge clk);
        chk("R8 one edge old", state_byte, 8'h00);
        @(negedge clk);
        chk("R8 two edges new", state_byte, 8'h05);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            apply(8'($urandom), 4'($urandom), 4'($urandom));
        end

        done = 1'b1;
        finish_run();
    end
endmodule